// File: doc/BRIEF.md
# Presettable Four-Bit Counter with Cascade Carry

This block is a synchronous binary up-counter. Every change of its state happens on the rising edge of one clock. On each edge it does exactly one of four things. It can return to zero, take a new value from a parallel data input, advance by one, or keep its present value. The choice follows a fixed priority among two active-low controls and two enables.

Counting needs both enables high. The carry output is high when the count holds its maximum value and the second enable is also high. Several copies can therefore be chained into a wider counter. To chain them, wire each stage's carry output to the second enable of the next stage, and drive all the first enables from a shared count request. A higher stage then advances only on the cycle in which every lower stage wraps.

Top module: `ld_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, `cnt` becomes 0 after that edge, whatever `ld_n`, `en_p`, `en_t` and `din` are.
- R2: When `clr_n` is 1 and `ld_n` is 0 at a rising edge, `cnt` takes the value of `din` after that edge, whatever the enables are.
- R3: When `clr_n` and `ld_n` are both 1 and `en_p` and `en_t` are both 1 at a rising edge, `cnt` rises by one after that edge.
- R4: When `clr_n` and `ld_n` are both 1 and at least one of `en_p`, `en_t` is 0 at a rising edge, `cnt` keeps its value.
- R5: Advancing from the all-ones value (15 at the default width) gives 0. The edge at which `carry_out` and `en_p` are both 1 with no clear and no load leaves `cnt` at 0.
- R6: `carry_out` is 1 exactly when `cnt` is all ones and `en_t` is 1. It follows `en_t` combinationally, without waiting for a clock edge.
- R7: While `en_t` is 0, `carry_out` is 0, even when `cnt` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by all state |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| ld_n | input | 1 | Synchronous parallel load, active low, second priority |
| en_p | input | 1 | Count enable that does not reach the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH (4) | Value taken by a load |
| cnt | output | WIDTH (4) | Present count |
| carry_out | output | 1 | Terminal-count carry for cascading |

## Verification
Assertions check every cycle the outcome of each action: clear to zero, load of the sampled data, increment, hold when either enable is low, and a carry-qualified increment that lands on zero. They also check that a low `en_t` keeps the carry low. The priority ordering, the exact clear–load–count-through-wrap–inhibit sequence, and the fact that the carry moves with `en_t` between clock edges appear only in the bench's scenarios. So does a full sixteen-step wrap with a carry check at every step.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

    // Action chosen for the next rising edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_COUNT = 2'd1,
        ACT_LOAD  = 2'd2,
        ACT_CLEAR = 2'd3
    } ctr_action_e;

endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
    import ctr_pkg::*;
(
    input  logic        clr_n,
    input  logic        ld_n,
    input  logic        en_p,
    input  logic        en_t,
    output ctr_action_e action
);

    // Priority: clear, then load, then counting with both enables.
    always_comb begin
        if (!clr_n) begin
            action = ACT_CLEAR;
        end else if (!ld_n) begin
            action = ACT_LOAD;
        end else if (en_p && en_t) begin
            action = ACT_COUNT;
        end else begin
            action = ACT_HOLD;
        end
    end

    // R1 guard: an asserted clear always wins.
    always_comb begin
        if (!clr_n) begin
            a_clear_wins_r1: assert (action == ACT_CLEAR)
                else $error("clear did not take priority");
        end
    end

endmodule

// File: rtl/ctr_next.sv
module ctr_next
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  ctr_action_e      action,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] nxt
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        unique case (action)
            ACT_CLEAR: nxt = '0;
            ACT_LOAD:  nxt = din;
            ACT_COUNT: nxt = cur + ONE;  // wraps naturally at all ones
            default:   nxt = cur;
        endcase
    end

endmodule

// File: rtl/ctr_carry.sv
module ctr_carry #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             en_t,
    output logic             carry
);

    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

    logic at_top;

    always_comb begin
        at_top = (cur == TOP);
        carry  = at_top && en_t;
    end

endmodule

// File: rtl/ld_counter.sv
module ld_counter
    import ctr_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             ld_n,
    input  logic             en_p,
    input  logic             en_t,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] cnt,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } ctr_state_t;

    ctr_state_t  state_d;
    ctr_state_t  state_q;
    ctr_action_e action;
    logic [WIDTH-1:0] cnt_nxt;

    ctr_ctrl u_ctrl (
        .clr_n  (clr_n),
        .ld_n   (ld_n),
        .en_p   (en_p),
        .en_t   (en_t),
        .action (action)
    );

    ctr_next #(.WIDTH(WIDTH)) u_next (
        .action (action),
        .cur    (state_q.cnt),
        .din    (din),
        .nxt    (cnt_nxt)
    );

    ctr_carry #(.WIDTH(WIDTH)) u_carry (
        .cur   (state_q.cnt),
        .en_t  (en_t),
        .carry (carry_out)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = cnt_nxt;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign cnt = state_q.cnt;

    // Assertion arming: the count is defined only after a first clear.
    logic armed_q = 1'b0;
    always_ff @(posedge clk) begin
        if (!clr_n) begin
            armed_q <= 1'b1;
        end
    end

    p_clear_r1: assert property (@(posedge clk) disable iff (!armed_q)
        !clr_n |=> (cnt == '0));

    p_load_r2: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && !ld_n) |=> (cnt == $past(din)));

    p_count_r3: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && en_p && en_t) |=> (cnt == $past(cnt) + ONE));

    p_hold_r4: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && !(en_p && en_t)) |=> $stable(cnt));

    p_wrap_r5: assert property (@(posedge clk) disable iff (!armed_q)
        (clr_n && ld_n && en_p && carry_out) |=> (cnt == '0));

    p_gate_r7: assert property (@(posedge clk) disable iff (!armed_q)
        !en_t |-> !carry_out);

endmodule

// File: tb/ld_counter_tb_top.sv
`timescale 1ns/1ps
module ld_counter_tb_top;

    localparam int W = 4;
    localparam int NV = 16;

    logic         clk = 1'b0;
    logic         clr_n = 1'b1;
    logic         ld_n = 1'b1;
    logic         en_p = 1'b0;
    logic         en_t = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] cnt;
    logic         carry_out;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ld_counter #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .clr_n     (clr_n),
        .ld_n      (ld_n),
        .en_p      (en_p),
        .en_t      (en_t),
        .din       (din),
        .cnt       (cnt),
        .carry_out (carry_out)
    );

    // Vector layout: {clr_n, ld_n, en_p, en_t, din[3:0], expected cnt[3:0]}
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 4'd0,  4'd0 },  // R1 clear
        {1'b1, 1'b0, 1'b0, 1'b0, 4'd12, 4'd12},  // R2 load 12
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd13},  // R3
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd14},
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd15},  // R6 carry high here
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd0 },  // R5 wrap
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd1 },
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd0,  4'd2 },
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  4'd2 },  // R4 en_p low
        {1'b1, 1'b1, 1'b1, 1'b0, 4'd0,  4'd2 },  // R4 en_t low
        {1'b1, 1'b0, 1'b1, 1'b0, 4'd15, 4'd15},  // R2 load, R7 carry low
        {1'b1, 1'b1, 1'b0, 1'b1, 4'd3,  4'd15},  // R4 hold, R6 carry high
        {1'b1, 1'b1, 1'b0, 1'b0, 4'd3,  4'd15},  // R7 carry low
        {1'b0, 1'b0, 1'b1, 1'b1, 4'd5,  4'd0 },  // R1 beats load and count
        {1'b1, 1'b0, 1'b1, 1'b1, 4'd9,  4'd9 },  // R2 beats count
        {1'b1, 1'b1, 1'b1, 1'b1, 4'd9,  4'd10}   // R3
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string tag_of(input logic c, input logic l, input logic p, input logic t);
        if (!c) return "R1";
        if (!l) return "R2";
        if (p && t) return "R3";
        return "R4";
    endfunction

    // Drive at the falling edge, one rising edge, sample just before the next falling edge.
    task automatic step(input logic c, input logic l, input logic p, input logic t, input logic [W-1:0] d);
        @(negedge clk);
        clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        // Reset state through a clear (R1), with load and enables driven.
        step(1'b0, 1'b0, 1'b1, 1'b1, 4'd7);
        check(cnt == 4'd0, "R1", cnt, 0);
        check(carry_out == 1'b0, "R6", carry_out, 0);

        // Table walk: clear, load 12, count through the wrap, then inhibit.
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            logic exp_c;
            v = VEC[i];
            step(v[11], v[10], v[9], v[8], v[7:4]);
            check(cnt == v[3:0], tag_of(v[11], v[10], v[9], v[8]), cnt, v[3:0]);
            exp_c = v[8] && (v[3:0] == 4'd15);
            check(carry_out == exp_c, exp_c ? "R6" : "R7", carry_out, exp_c);
        end

        // Full sixteen-step wrap from zero, carry checked at every step (R3, R5, R6).
        step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
        for (int k = 1; k <= 16; k++) begin
            logic [W-1:0] e;
            e = W'(k);
            step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
            check(cnt == e, (e == 4'd0) ? "R5" : "R3", cnt, e);
            check(carry_out == (e == 4'd15), "R6", carry_out, (e == 4'd15));
        end

        // Carry follows en_t between edges at the top value (R6, R7).
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'd15);
        check(cnt == 4'd15, "R2", cnt, 15);
        check(carry_out == 1'b0, "R7", carry_out, 0);
        #0.5 en_t = 1'b1;
        #0.2;
        check(carry_out == 1'b1, "R6", carry_out, 1);
        en_t = 1'b0;
        #0.2;
        check(carry_out == 1'b0, "R7", carry_out, 0);

        // Carry-qualified advance lands on zero (R5).
        step(1'b1, 1'b1, 1'b1, 1'b1, 4'd0);
        check(cnt == 4'd0, "R5", cnt, 0);

        // Hold with only en_t high at a non-top value keeps carry low (R4, R6).
        step(1'b1, 1'b0, 1'b0, 1'b0, 4'd6);
        step(1'b1, 1'b1, 1'b0, 1'b1, 4'd1);
        check(cnt == 4'd6, "R4", cnt, 6);
        check(carry_out == 1'b0, "R6", carry_out, 0);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule